// File: doc/BRIEF.md
# Shared Command/Data Bus Front-End Decoder

This block is the front end of a wide associative memory. Instructions and data share one 32-bit bus. Each clock in which chip enable is low is one bus cycle. Two active-low strobes, write and command-mode, select the kind of cycle.

Command words do one of two things. Some choose where later data cycles go: the comparand, the mask or the memory array. Others address one of a small set of 16-bit internal registers, and a direction flag in the word picks read or write. Each register operation is split across two bus cycles:

- A register write sends its value in the command-write cycle that comes next.
- A register read is armed by its command word and is answered only by the command read that comes next.
- A bus cycle of any other kind cancels the pending operation.

On a command read, the upper half of the bus carries the upper status bits, or zeros when the page-address register is being read. The lower half carries either the lower status bits or the register value. The data cycles pass straight through to the downstream memory side. They are tagged with the current destination.

All outputs are decoded combinationally from the current bus strobes and the registered decoder state. State changes at the end of each bus cycle. The bus is driven only during read-type cycles. The control and data pins are plain strobes with no handshake, because the bus cycle itself sets the pace.

Top module: `mbd_top`

## Requirements
- R1: With `ce_n` low, the strobes `we_n`/`cm_n` decode as follows:
  - 0/0 is a command write.
  - 1/0 is a command read.
  - 0/1 is a data write.
  - 1/1 is a data read.
  - With `ce_n` high, no bus cycle takes place.
- R2: `dq_oe` is 1 only in command-read and data-read cycles. In every other clock, `dq_out` is all zeros.
- R3: The command word is laid out as follows:
  - Bit 15 is 1 for a register instruction. In that case bit 14 is the direction flag (0 = read, 1 = write) and bits 1:0 select register 0..3.
  - With bit 15 at 0, bits 1:0 are a destination code: 0 = comparand, 1 = mask, 2 = memory. Code 3 leaves the destination unchanged.
- R4: A register instruction with the flag at 1, followed by a command write as the next bus cycle, loads `dq_in[15:0]` of that second cycle into the selected register. That second cycle is not decoded as an instruction.
- R5: A register instruction with the flag at 0, followed by a command read as the next bus cycle, returns the selected register on `dq_out[15:0]` and `status_i[31:16]` on `dq_out[31:16]`.
- R6: When the register read is register 1 (page address), `dq_out[31:16]` is zero.
- R7: If the next bus cycle after an armed read or write is of a different kind, the pending operation is cancelled with no register change. That cycle performs its normal function.
- R8: Clocks with `ce_n` high do not count as bus cycles. They leave a pending operation and the destination unchanged.
- R9: A command read with no armed register read returns `status_i` in full.
- R10: In a data write, `dw_valid` is 1, `dw_data` equals `dq_in` and `dw_dest` is the current destination. In a data read, `dr_req` is 1, `dr_dest` is the current destination and `dq_out` equals `dr_data`.
- R11: Synchronous reset `rst` clears all registers to zero, sets the destination to comparand and drops any pending operation. `ce_n` must stay high while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| cm_n | input | 1 | Command-mode strobe, active low |
| dq_in | input | 32 | Bus value driven by the host |
| dq_out | output | 32 | Bus value driven by the block |
| dq_oe | output | 1 | Output enable for `dq_out` |
| status_i | input | 32 | Status word from the device core |
| dw_valid | output | 1 | Data-write cycle strobe |
| dw_dest | output | 2 | Destination of the data write |
| dw_data | output | 32 | Data-write value |
| dr_req | output | 1 | Data-read cycle strobe |
| dr_dest | output | 2 | Destination of the data read |
| dr_data | input | 32 | Read value returned by the destination |

## Verification
The bench drives all eight combinations of the three strobes and checks the enable and the data strobes. This separates the cycle classes and shows that chip enable gates them.

Every register is written and then read back. Each value carries its index, and a status pattern with distinct halves is applied, so a wrong select, a swapped half or a missing page-zero rule each show up as a different value.

Armed reads and writes are followed by each other cycle kind and by idle clocks, which separates cancellation from holding. A sweep over all four destination codes shows the routing and that code 3 is ignored.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int DQ_W      = 32;
  localparam int HALF_W    = DQ_W / 2;
  localparam int REGOP_BIT = 15;
  localparam int DIR_BIT   = 14;

  typedef enum logic [2:0] {
    CYC_NONE   = 3'd0,
    CYC_CMD_WR = 3'd1,
    CYC_CMD_RD = 3'd2,
    CYC_DAT_WR = 3'd3,
    CYC_DAT_RD = 3'd4
  } cyc_e;

  typedef enum logic [1:0] {
    DST_CMP  = 2'd0,
    DST_MSK  = 2'd1,
    DST_MEM  = 2'd2,
    DST_KEEP = 2'd3
  } dest_e;
endpackage

// File: rtl/mbd_classify.sv
module mbd_classify
  import mbd_pkg::*;
(
  input  logic ce_n,
  input  logic we_n,
  input  logic cm_n,
  output cyc_e cyc
);
  always_comb begin
    if (ce_n) begin
      cyc = CYC_NONE;
    end else begin
      unique case ({cm_n, we_n})
        2'b00:   cyc = CYC_CMD_WR;
        2'b01:   cyc = CYC_CMD_RD;
        2'b10:   cyc = CYC_DAT_WR;
        default: cyc = CYC_DAT_RD;
      endcase
    end
  end
endmodule

// File: rtl/mbd_regfile.sv
module mbd_regfile #(
  parameter int NREG  = 4,
  parameter int REG_W = 16,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_val
);
  logic [NREG-1:0][REG_W-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (we && wr_idx == IDX_W'(g)) begin
        regs[g] <= wr_val;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IDX_W'(i)) rd_val = regs[i];
    end
  end

  // R4
  reg_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs));
endmodule

// File: rtl/mbd_seq.sv
module mbd_seq
  import mbd_pkg::*;
#(
  parameter int NREG = 4,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  cyc_e             cyc,
  input  logic [DQ_W-1:0]  dq_in,
  output logic             reg_we,
  output logic             rd_hit,
  output logic [IDX_W-1:0] sel,
  output dest_e            dest
);
  logic       pend_rd;
  logic       pend_wr;
  logic       is_reg;
  logic       dir_wr;
  logic [1:0] code;
  logic       is_cmd;
  logic       dest_set;

  assign is_reg   = dq_in[REGOP_BIT];
  assign dir_wr   = dq_in[DIR_BIT];
  assign code     = dq_in[1:0];
  assign is_cmd   = (cyc == CYC_CMD_WR) && !pend_wr;
  assign dest_set = is_cmd && !is_reg && (code != DST_KEEP);
  assign reg_we   = (cyc == CYC_CMD_WR) && pend_wr;
  assign rd_hit   = (cyc == CYC_CMD_RD) && pend_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rd <= 1'b0;
      pend_wr <= 1'b0;
      sel     <= '0;
      dest    <= DST_CMP;
    end else if (cyc != CYC_NONE) begin
      pend_rd <= 1'b0;
      pend_wr <= 1'b0;
      if (is_cmd && is_reg) begin
        pend_rd <= !dir_wr;
        pend_wr <= dir_wr;
        sel     <= dq_in[IDX_W-1:0];
      end
      if (dest_set) dest <= dest_e'(code);
    end
  end

  // R3
  one_pend_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pend_rd, pend_wr}));

  // R7
  rd_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_rd && cyc != CYC_NONE && cyc != CYC_CMD_WR) |=> !pend_rd);

  // R7
  wr_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_wr && cyc != CYC_NONE) |=> !pend_wr);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_NONE) |=> $stable({pend_rd, pend_wr, sel, dest}));
endmodule

// File: rtl/mbd_top.sv
module mbd_top
  import mbd_pkg::*;
#(
  parameter int NREG     = 4,
  parameter int PAGE_IDX = 1,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              cm_n,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  input  logic [DQ_W-1:0]   status_i,
  output logic              dw_valid,
  output logic [1:0]        dw_dest,
  output logic [DQ_W-1:0]   dw_data,
  output logic              dr_req,
  output logic [1:0]        dr_dest,
  input  logic [DQ_W-1:0]   dr_data
);
  cyc_e              cyc;
  logic              reg_we;
  logic              rd_hit;
  logic [IDX_W-1:0]  sel;
  dest_e             dest;
  logic [HALF_W-1:0] reg_val;
  logic [HALF_W-1:0] hi_half;

  mbd_classify u_cls (
    .ce_n (ce_n),
    .we_n (we_n),
    .cm_n (cm_n),
    .cyc  (cyc)
  );

  mbd_seq #(.NREG(NREG)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .cyc    (cyc),
    .dq_in  (dq_in),
    .reg_we (reg_we),
    .rd_hit (rd_hit),
    .sel    (sel),
    .dest   (dest)
  );

  mbd_regfile #(.NREG(NREG), .REG_W(HALF_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .wr_idx (sel),
    .wr_val (dq_in[HALF_W-1:0]),
    .rd_idx (sel),
    .rd_val (reg_val)
  );

  assign hi_half = (sel == IDX_W'(PAGE_IDX)) ? '0 : status_i[DQ_W-1:HALF_W];

  always_comb begin
    unique case (cyc)
      CYC_CMD_RD: dq_out = rd_hit ? {hi_half, reg_val} : status_i;
      CYC_DAT_RD: dq_out = dr_data;
      default:    dq_out = '0;
    endcase
  end

  assign dq_oe    = (cyc == CYC_CMD_RD) || (cyc == CYC_DAT_RD);
  assign dw_valid = (cyc == CYC_DAT_WR);
  assign dw_data  = dq_in;
  assign dw_dest  = dest;
  assign dr_req   = (cyc == CYC_DAT_RD);
  assign dr_dest  = dest;

  // R11
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_hold_chk: assert (ce_n) else $error("chip enable active during reset");
    end
  end

  // R6
  page_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel == IDX_W'(PAGE_IDX)) |-> (dq_out[DQ_W-1:HALF_W] == '0));

  // R2
  oe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq_out == '0));
endmodule

// File: tb/mbd_top_tb_top.sv
`timescale 1ns/1ps
module mbd_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, cm_n = 1'b1;
  logic [31:0] dq_in = '0, status_i = 32'hA5C3_0F1E, dr_data = '0;
  logic [31:0] dq_out, dw_data;
  logic        dq_oe, dw_valid, dr_req;
  logic [1:0]  dw_dest, dr_dest;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbd_top dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cm_n(cm_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .status_i(status_i),
    .dw_valid(dw_valid), .dw_dest(dw_dest), .dw_data(dw_data),
    .dr_req(dr_req), .dr_dest(dr_dest), .dr_data(dr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one clock; sample 1 ns before the following rising edge
  task automatic bus(input logic ce, input logic we, input logic cm, input logic [31:0] d);
    @(negedge clk);
    ce_n = ce; we_n = we; cm_n = cm; dq_in = d;
    #3;
  endtask

  function automatic logic [31:0] regcmd(input logic f, input int idx);
    return 32'h0000_8000 | (32'(f) << 14) | 32'(idx);
  endfunction

  task automatic reg_read(input int idx, input string req, input logic [15:0] exp_lo);
    logic [15:0] hi;
    hi = (idx == 1) ? 16'h0 : status_i[31:16];
    bus(0, 0, 0, regcmd(0, idx));
    bus(0, 1, 0, 32'h0);
    check(req, dq_out, {hi, exp_lo});
  endtask

  task automatic reg_write(input int idx, input logic [15:0] v);
    bus(0, 0, 0, regcmd(1, idx));
    bus(0, 0, 0, {16'hDEAD, v});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state / R9 unarmed command read
    bus(1, 1, 1, 32'h0);
    check("R11 oe after reset", {31'h0, dq_oe}, 32'h0);
    bus(0, 1, 0, 32'h0);
    check("R9 status on unarmed read", dq_out, status_i);
    for (int i = 0; i < 4; i++) reg_read(i, "R11 register reset value", 16'h0);
    bus(0, 0, 1, 32'h1234_5678);
    check("R11 reset destination", {30'h0, dw_dest}, 32'h0);

    // R1 / R2 strobe sweep
    for (int k = 0; k < 8; k++) begin
      logic ce, we, cm, act, rd, dw;
      ce = k[2]; we = k[1]; cm = k[0];
      dr_data = 32'h0BAD_F00D + 32'(k);
      bus(ce, we, cm, (k == 0) ? 32'h0000_0003 : 32'h7777_0000 + 32'(k));
      act = !ce;
      rd = act && we;
      dw = act && !we && cm;
      check("R2 output enable", {31'h0, dq_oe}, {31'h0, rd});
      if (!rd) check("R2 released bus is zero", dq_out, 32'h0);
      check("R1 data write strobe", {31'h0, dw_valid}, {31'h0, dw});
      check("R1 data read strobe", {31'h0, dr_req}, {31'h0, act && we && cm});
    end

    // R4 / R5 / R6 register sweep with two status patterns
    for (int p = 0; p < 2; p++) begin
      status_i = (p == 0) ? 32'hA5C3_0F1E : 32'h3C69_E187;
      for (int i = 0; i < 4; i++) reg_write(i, 16'h1111 * 16'(i + 1) ^ 16'(p * 16'h0F0F));
      for (int i = 0; i < 4; i++)
        reg_read(i, (i == 1) ? "R6 page read upper zero" : "R5 register read",
                 16'h1111 * 16'(i + 1) ^ 16'(p * 16'h0F0F));
    end
    bus(0, 0, 0, regcmd(1, 0));
    bus(0, 0, 0, 32'h0000_8002);
    check("R4 value cycle not decoded as instruction", {31'h0, dq_oe}, 32'h0);
    reg_read(0, "R4 value cycle loads register", 16'h8002);
    reg_read(2, "R4 other register untouched", 16'h3333 ^ 16'h0F0F);

    // R7 cancellation
    bus(0, 0, 0, regcmd(0, 3));
    bus(0, 0, 1, 32'hCAFE_0001);
    check("R7 data write proceeds", {31'h0, dw_valid}, 32'h1);
    bus(0, 1, 0, 32'h0);
    check("R7 read cancelled by data write", dq_out, status_i);
    bus(0, 0, 0, regcmd(0, 3));
    dr_data = 32'h1357_9BDF;
    bus(0, 1, 1, 32'h0);
    check("R7 data read proceeds", dq_out, 32'h1357_9BDF);
    bus(0, 1, 0, 32'h0);
    check("R7 read cancelled by data read", dq_out, status_i);
    bus(0, 0, 0, regcmd(0, 3));
    bus(0, 0, 0, 32'h0000_0003);
    bus(0, 1, 0, 32'h0);
    check("R7 read cancelled by command write", dq_out, status_i);
    bus(0, 0, 0, regcmd(1, 2));
    bus(0, 0, 1, 32'h0000_BEEF);
    check("R7 data write after cancelled write", dw_data, 32'h0000_BEEF);
    reg_read(2, "R7 cancelled write leaves register", 16'h3333 ^ 16'h0F0F);
    bus(0, 0, 0, regcmd(1, 2));
    bus(0, 1, 0, 32'h0);
    check("R7 command read after armed write shows status", dq_out, status_i);
    reg_read(2, "R7 write cancelled by command read", 16'h3333 ^ 16'h0F0F);

    // R8 idle clocks hold pending operations
    bus(0, 0, 0, regcmd(0, 3));
    repeat (3) bus(1, 0, 0, 32'hFFFF_FFFF);
    bus(0, 1, 0, 32'h0);
    check("R8 pending read survives idle", dq_out, {status_i[31:16], 16'h4444 ^ 16'h0F0F});
    bus(0, 0, 0, regcmd(1, 3));
    repeat (2) bus(1, 1, 1, 32'h0);
    bus(0, 0, 0, 32'h0000_5A5A);
    reg_read(3, "R8 pending write survives idle", 16'h5A5A);

    // R10 / R3 destination sweep
    begin
      logic [1:0] cur;
      cur = 2'd0;
      for (int c = 0; c < 4; c++) begin
        bus(0, 0, 0, 32'(c));
        if (c != 3) cur = 2'(c);
        bus(0, 0, 1, 32'h0100_0000 * 32'(c + 1));
        check("R10 data write destination", {30'h0, dw_dest}, {30'h0, cur});
        check("R10 data write value", dw_data, 32'h0100_0000 * 32'(c + 1));
        dr_data = 32'hF0F0_0000 | 32'(c);
        bus(0, 1, 1, 32'h0);
        check("R10 data read destination", {30'h0, dr_dest}, {30'h0, cur});
        check("R10 data read value", dq_out, 32'hF0F0_0000 | 32'(c));
      end
      bus(1, 0, 0, 32'h0000_0001);
      bus(0, 0, 1, 32'h0);
      check("R3 idle does not decode command", {30'h0, dw_dest}, 32'h2);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule